// File: doc/BRIEF.md
# PMP Configuration Register File with Locking

This block stores the configuration bytes and address words of a set of physical memory protection entries (16 by default) and presents them through one word-wide register port. A port access picks either a configuration word or an address word by index. A configuration word holds one 8-bit entry byte in each byte lane of the machine word. An address word belongs to exactly one entry. The block drives all stored bytes and addresses, unchanged, to a region decoder downstream. It also reports which entries are enabled and how many there are.

Lock rules silently discard writes. An entry is frozen when its own lock bit is set. It is also frozen when the entry directly above it is locked and uses top-of-range matching, because that entry takes this entry's address as its lower bound. The lock state is taken from the stored values before the write. Each byte lane of a configuration write is judged on its own, so one word can update partly. A write to an index past the last entry does nothing, and a read of such an index returns zero in the affected lanes. When the machine word is 64 bits, a configuration write to an odd index is dropped.

Top module: `pmp_cfg_regfile`

## Requirements
- R1: After reset, every configuration byte and address word is zero, no entry is active and the active count is zero.
- R2: Configuration index k, byte lane i (bits 8i+7:8i) maps to entry 4k+i, for both writes and reads. A read returns the bytes little-endian, with the byte of the lowest entry in bits 7:0.
- R3: An address write at index k stores the full word in entry k, and an address read at index k returns it.
- R4: When bit 7 (lock) of an entry's configuration byte is set, writes to that entry's configuration byte and address word have no effect.
- R5: Entry i is also frozen when entry i+1 has bit 7 set and its mode field (bits 4:3) equals 01 (top-of-range). A locked successor with any other mode does not freeze entry i. The highest entry has no successor.
- R6: Within one configuration write, every byte lane is accepted or dropped by itself, so lanes of unlocked entries update even when other lanes target locked entries.
- R7: Writes whose entry index is not below the entry count change nothing. A read of such an index returns zero in every lane or word that falls outside.
- R8: When the word is 64 bits, a configuration write to an odd index changes nothing. An even index k covers entries 4k to 4k+7.
- R9: Entry i is active when its mode field (bits 4:3) is not 00. The active flags and the active count follow the stored bytes from the cycle after an accepted write.
- R10: While the write enable is low, no stored byte or address changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csrWrEn | input | 1 | Write strobe for the register port |
| csrSel | input | 1 | 0 selects a configuration word, 1 selects an address word |
| csrIdx | input | IDX_W | Word index |
| csrWdata | input | XLEN | Write data |
| csrRdata | output | XLEN | Read data for the current csrSel and csrIdx (combinational) |
| entryCfg | output | N*8 | All configuration bytes, entry e in bits 8e+7:8e |
| entryAddr | output | N*XLEN | All address words, entry e in word e |
| entryActive | output | N | One flag per entry whose mode is not off |
| activeCount | output | $clog2(N+1) | Number of active entries |

## Verification
A write takes effect at the rising edge where csrWrEn is high. The stored bytes, the address outputs, the active flags and the count therefore change one edge after the stimulus, and a read of the port shows the new value in the low phase that follows. Read data depends only on csrSel, csrIdx and the stored state, with no register in the path, so it is due in the same cycle as the index is applied. The bench applies every input on a falling edge and lets it take one rising edge. It then samples reads and outputs shortly after the next falling edge, when no register can be changing.

// File: rtl/pmp_cfg_pkg.sv
package pmp_cfg_pkg;

  localparam int CFG_LOCK_BIT = 7;
  localparam int CFG_MODE_LO  = 3;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_TOR = 2'b01;

  localparam logic SEL_CFG  = 1'b0;
  localparam logic SEL_ADDR = 1'b1;

  // Word-level strobes from control to datapath
  typedef struct packed {
    logic cfgWr;
    logic addrWr;
  } pmpStrobe_t;

endpackage

// File: rtl/pmp_cfg_ctrl.sv
module pmp_cfg_ctrl
  import pmp_cfg_pkg::*;
#(
  parameter int N     = 16,
  parameter int XLEN  = 32,
  parameter int IDX_W = 6
) (
  input  logic             csrWrEn,
  input  logic             csrSel,
  input  logic [IDX_W-1:0] csrIdx,
  input  logic [N*8-1:0]   cfgFlat,
  output pmpStrobe_t       strobe,
  output logic [N-1:0]     entryOpen
);

  localparam int BYTES = XLEN / 8;
  localparam int STEP  = BYTES / 4;

  logic oddDrop;
  logic [N-1:0] locked;

  generate
    if (XLEN == 64) begin : g_wide
      assign oddDrop = csrIdx[0];
    end else begin : g_narrow
      assign oddDrop = 1'b0;
    end
  endgenerate

  assign strobe.cfgWr  = csrWrEn && (csrSel == SEL_CFG) && !oddDrop;
  assign strobe.addrWr = csrWrEn && (csrSel == SEL_ADDR);

  generate
    for (genvar e = 0; e < N; e++) begin : g_entry
      localparam int CFG_IDX = (e / BYTES) * STEP;

      if (e == N - 1) begin : g_top
        assign locked[e] = cfgFlat[e*8+CFG_LOCK_BIT];
      end else begin : g_mid
        assign locked[e] = cfgFlat[e*8+CFG_LOCK_BIT] ||
                           (cfgFlat[(e+1)*8+CFG_LOCK_BIT] &&
                            (cfgFlat[(e+1)*8+CFG_MODE_LO +: 2] == MODE_TOR));
      end

      assign entryOpen[e] = !locked[e] &&
        ((csrSel == SEL_CFG) ? (csrIdx == IDX_W'(CFG_IDX))
                             : (csrIdx == IDX_W'(e)));
    end
  endgenerate

endmodule

// File: rtl/pmp_cfg_dp.sv
module pmp_cfg_dp
  import pmp_cfg_pkg::*;
#(
  parameter int N     = 16,
  parameter int XLEN  = 32,
  parameter int IDX_W = 6,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmpStrobe_t        strobe,
  input  logic [N-1:0]      entryOpen,
  input  logic              csrSel,
  input  logic [IDX_W-1:0]  csrIdx,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic [N*8-1:0]    cfgQ,
  output logic [N*XLEN-1:0] addrQ,
  output logic [N-1:0]      activeVec,
  output logic [CNT_W-1:0]  activeCnt
);

  localparam int BYTES = XLEN / 8;
  localparam int BW    = IDX_W + 3;

  generate
    for (genvar e = 0; e < N; e++) begin : g_store
      localparam int LANE = e % BYTES;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cfgQ[e*8 +: 8] <= '0;
        end else if (strobe.cfgWr && entryOpen[e]) begin
          cfgQ[e*8 +: 8] <= csrWdata[LANE*8 +: 8];
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          addrQ[e*XLEN +: XLEN] <= '0;
        end else if (strobe.addrWr && entryOpen[e]) begin
          addrQ[e*XLEN +: XLEN] <= csrWdata;
        end
      end

      assign activeVec[e] = (cfgQ[e*8+CFG_MODE_LO +: 2] != MODE_OFF);
    end
  endgenerate

  // Count from the mode fields directly, independent of activeVec
  always_comb begin
    activeCnt = '0;
    for (int e = 0; e < N; e++) begin
      if (cfgQ[e*8+CFG_MODE_LO +: 2] != MODE_OFF) begin
        activeCnt = activeCnt + CNT_W'(1);
      end
    end
  end

  logic [BW-1:0]   laneBase;
  logic [XLEN-1:0] cfgWord;
  logic [XLEN-1:0] addrWord;

  assign laneBase = {1'b0, csrIdx, 2'b00};

  always_comb begin
    cfgWord = '0;
    for (int l = 0; l < BYTES; l++) begin
      for (int e = 0; e < N; e++) begin
        if (laneBase + BW'(l) == BW'(e)) begin
          cfgWord[l*8 +: 8] = cfgQ[e*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    addrWord = '0;
    for (int e = 0; e < N; e++) begin
      if (csrIdx == IDX_W'(e)) begin
        addrWord = addrQ[e*XLEN +: XLEN];
      end
    end
  end

  assign csrRdata = (csrSel == SEL_ADDR) ? addrWord : cfgWord;

endmodule

// File: rtl/pmp_cfg_regfile.sv
module pmp_cfg_regfile
  import pmp_cfg_pkg::*;
#(
  parameter int N     = 16,
  parameter int XLEN  = 32,
  parameter int IDX_W = 6,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic              csrSel,
  input  logic [IDX_W-1:0]  csrIdx,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic [N*8-1:0]    entryCfg,
  output logic [N*XLEN-1:0] entryAddr,
  output logic [N-1:0]      entryActive,
  output logic [CNT_W-1:0]  activeCount
);

  pmpStrobe_t   strobe;
  logic [N-1:0] entryOpen;

  pmp_cfg_ctrl #(.N(N), .XLEN(XLEN), .IDX_W(IDX_W)) u_ctrl (
    .csrWrEn   (csrWrEn),
    .csrSel    (csrSel),
    .csrIdx    (csrIdx),
    .cfgFlat   (entryCfg),
    .strobe    (strobe),
    .entryOpen (entryOpen)
  );

  pmp_cfg_dp #(.N(N), .XLEN(XLEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .entryOpen (entryOpen),
    .csrSel    (csrSel),
    .csrIdx    (csrIdx),
    .csrWdata  (csrWdata),
    .csrRdata  (csrRdata),
    .cfgQ      (entryCfg),
    .addrQ     (entryAddr),
    .activeVec (entryActive),
    .activeCnt (activeCount)
  );

endmodule

// File: rtl/pmp_cfg_regfile_chk.sv
module pmp_cfg_regfile_chk #(
  parameter int N     = 16,
  parameter int XLEN  = 32,
  parameter int IDX_W = 6,
  parameter int CNT_W = $clog2(N + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              csrWrEn,
  input logic              csrSel,
  input logic [IDX_W-1:0]  csrIdx,
  input logic [XLEN-1:0]   csrRdata,
  input logic [N*8-1:0]    entryCfg,
  input logic [N*XLEN-1:0] entryAddr,
  input logic [N-1:0]      entryActive,
  input logic [CNT_W-1:0]  activeCount
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (entryCfg == '0 && entryAddr == '0 && activeCount == '0));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !csrWrEn |=> ($stable(entryCfg) && $stable(entryAddr)));

  assert_count_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    activeCount == CNT_W'($countones(entryActive)));

  assert_oob_addr_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (csrSel && (int'(csrIdx) >= N)) |-> (csrRdata == '0));

  generate
    for (genvar e = 0; e < N; e++) begin : g_ent
      assert_own_lock_cfg_R4: assert property (@(posedge clk) disable iff (!rstN)
        entryCfg[e*8+7] |=> $stable(entryCfg[e*8 +: 8]));
      assert_own_lock_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
        entryCfg[e*8+7] |=> $stable(entryAddr[e*XLEN +: XLEN]));
      if (e < N - 1) begin : g_succ
        assert_tor_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
          (entryCfg[(e+1)*8+7] && entryCfg[(e+1)*8+3 +: 2] == 2'b01)
          |=> ($stable(entryCfg[e*8 +: 8]) && $stable(entryAddr[e*XLEN +: XLEN])));
      end
    end
    if (XLEN == 64) begin : g_wide
      assert_odd_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
        (csrWrEn && !csrSel && csrIdx[0]) |=> $stable(entryCfg));
    end
  endgenerate

endmodule

bind pmp_cfg_regfile pmp_cfg_regfile_chk #(.N(N), .XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .csrWrEn     (csrWrEn),
  .csrSel      (csrSel),
  .csrIdx      (csrIdx),
  .csrRdata    (csrRdata),
  .entryCfg    (entryCfg),
  .entryAddr   (entryAddr),
  .entryActive (entryActive),
  .activeCount (activeCount)
);

// File: tb/pmp_cfg_regfile_test.sv
module pmp_cfg_regfile_test;

  localparam int N = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  // 32-bit instance
  logic        wrEn = 1'b0;
  logic        sel = 1'b0;
  logic [5:0]  idx = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [N*8-1:0]  cfgOut;
  logic [N*32-1:0] addrOut;
  logic [N-1:0]    actOut;
  logic [4:0]      cntOut;

  // 64-bit instance
  logic        wrEn64 = 1'b0;
  logic        sel64 = 1'b0;
  logic [5:0]  idx64 = '0;
  logic [63:0] wd64 = '0;
  logic [63:0] rd64;
  logic [N*8-1:0]  cfgOut64;
  logic [N*64-1:0] addrOut64;
  logic [N-1:0]    actOut64;
  logic [4:0]      cntOut64;

  pmp_cfg_regfile #(.N(N), .XLEN(32), .IDX_W(6)) uut (
    .clk(clk), .rstN(rstN), .csrWrEn(wrEn), .csrSel(sel), .csrIdx(idx),
    .csrWdata(wd), .csrRdata(rd), .entryCfg(cfgOut), .entryAddr(addrOut),
    .entryActive(actOut), .activeCount(cntOut));

  pmp_cfg_regfile #(.N(N), .XLEN(64), .IDX_W(6)) uut64 (
    .clk(clk), .rstN(rstN), .csrWrEn(wrEn64), .csrSel(sel64), .csrIdx(idx64),
    .csrWdata(wd64), .csrRdata(rd64), .entryCfg(cfgOut64), .entryAddr(addrOut64),
    .entryActive(actOut64), .activeCount(cntOut64));

  int compared = 0;
  int mismatched = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic s, input int i, input logic [31:0] d);
    @(negedge clk);
    sel = s; idx = 6'(i); wd = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd32(input logic s, input int i, input logic [31:0] exp, input string tag);
    sel = s; idx = 6'(i);
    #2;
    check(tag, {32'h0, rd}, {32'h0, exp});
  endtask

  task automatic wr64(input logic s, input int i, input logic [63:0] d);
    @(negedge clk);
    sel64 = s; idx64 = 6'(i); wd64 = d; wrEn64 = 1'b1;
    @(negedge clk);
    wrEn64 = 1'b0;
  endtask

  task automatic rdw(input logic s, input int i, input logic [63:0] exp, input string tag);
    sel64 = s; idx64 = 6'(i);
    #2;
    check(tag, rd64, exp);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 4; k++) rd32(1'b0, k, 32'h0, "R1 cfg word after reset");
    rd32(1'b1, 0, 32'h0, "R1 addr word after reset");
    check("R1 active flags after reset", 64'(actOut), 64'h0);
    check("R1 count after reset", 64'(cntOut), 64'h0);
    check("R1 64-bit cfg outputs after reset", cfgOut64[63:0], 64'h0);
  endtask

  task automatic t_pack;
    wr32(1'b0, 0, 32'h1F10_0800);
    rd32(1'b0, 0, 32'h1F10_0800, "R2 cfg word readback");
    check("R2 entry3 byte on output", 64'(cfgOut[3*8 +: 8]), 64'h1F);
    check("R2 entry1 byte on output", 64'(cfgOut[1*8 +: 8]), 64'h08);
    rd32(1'b0, 1, 32'h0, "R2 neighbour word untouched");
    check("R9 active flags", 64'(actOut), 64'h000E);
    check("R9 active count", 64'(cntOut), 64'd3);
  endtask

  task automatic t_addr;
    wr32(1'b1, 5, 32'hDEAD_BEEF);
    rd32(1'b1, 5, 32'hDEAD_BEEF, "R3 addr readback");
    rd32(1'b1, 4, 32'h0, "R3 other addr untouched");
    check("R3 addr output word", 64'(addrOut[5*32 +: 32]), 64'hDEAD_BEEF);
  endtask

  task automatic t_ownlock;
    wr32(1'b1, 4, 32'h0000_1234);
    wr32(1'b0, 1, 32'h0000_009F);
    wr32(1'b1, 4, 32'h0000_FFFF);
    rd32(1'b1, 4, 32'h0000_1234, "R4 locked addr write dropped");
    wr32(1'b0, 1, 32'h5555_5500);
    rd32(1'b0, 1, 32'h5555_559F, "R6 partial word: locked lane kept, others written");
    wr32(1'b1, 3, 32'h0000_0077);
    rd32(1'b1, 3, 32'h0000_0077, "R5 locked non-TOR successor does not freeze");
    check("R9 count after mixed writes", 64'(cntOut), 64'd7);
  endtask

  task automatic t_torlock;
    wr32(1'b1, 8, 32'h0000_AAAA);
    wr32(1'b0, 2, 32'h0000_8800);
    wr32(1'b1, 8, 32'h0000_BBBB);
    rd32(1'b1, 8, 32'h0000_AAAA, "R5 TOR successor freezes addr");
    wr32(1'b0, 2, 32'h1122_3344);
    rd32(1'b0, 2, 32'h1122_8800, "R5 TOR successor freezes cfg byte");
    wr32(1'b1, 9, 32'h0000_0001);
    rd32(1'b1, 9, 32'h0, "R4 own lock on TOR entry");
    check("R9 count after TOR lock", 64'(cntOut), 64'd9);
    wr32(1'b0, 3, 32'h8800_0000);
    wr32(1'b1, 14, 32'h0000_0005);
    rd32(1'b1, 14, 32'h0, "R5 highest entry locks entry below");
    rd32(1'b0, 3, 32'h8800_0000, "R5 highest entry byte stored");
  endtask

  task automatic t_oob;
    wr32(1'b1, 16, 32'hFFFF_FFFF);
    rd32(1'b1, 16, 32'h0, "R7 out-of-range addr read zero");
    rd32(1'b1, 20, 32'h0, "R7 far out-of-range addr read zero");
    wr32(1'b0, 4, 32'hFFFF_FFFF);
    rd32(1'b0, 4, 32'h0, "R7 out-of-range cfg read zero");
    rd32(1'b0, 0, 32'h1F10_0800, "R7 in-range cfg unchanged");
    check("R7 count unchanged", 64'(cntOut), 64'd10);
  endtask

  task automatic t_idle;
    @(negedge clk);
    sel = 1'b1; idx = 6'd2; wd = 32'h0000_CAFE; wrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd32(1'b1, 2, 32'h0, "R10 no write without enable");
  endtask

  task automatic t_wide;
    wr64(1'b0, 0, 64'h0807_0605_0403_0201);
    rdw(1'b0, 0, 64'h0807_0605_0403_0201, "R8 even index covers eight entries");
    rdw(1'b0, 1, 64'h0000_0000_0807_0605, "R8 odd index read overlaps");
    wr64(1'b0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    rdw(1'b0, 0, 64'h0807_0605_0403_0201, "R8 odd index write dropped");
    rdw(1'b0, 2, 64'h0, "R8 upper entries untouched");
    wr64(1'b0, 2, 64'h1010_1010_1010_1010);
    rdw(1'b0, 2, 64'h1010_1010_1010_1010, "R8 index 2 covers entries 8-15");
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pack();
    t_addr();
    t_ownlock();
    t_torlock();
    t_oob();
    t_idle();
    t_wide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule